// File: doc/BRIEF.md
# Cache Flush and Writeback Sequencer

This block carries out whole-cache maintenance for a small write-back data cache. It holds the cache's per-line state, tag and data in register arrays. It accepts one of two commands. The plain flush command discards the contents of every line. The clean-and-flush command first copies every dirty line out over a request/acknowledge bus and then discards all lines. After the lines are handled, the block tells an outer, second-level cache what to do by raising an encoded special-cycle indication. It holds that indication until the bus acknowledges it.

The scan visits the lines in a fixed order. Sets are taken in ascending order, and within a set the ways are taken from 0 upward. A line that is dirty costs one bus handshake. Any other line is cleared in one cycle. A fill port loads lines while the block is idle, and a lookup port reads back the state of any line. Together these two ports stand in for the normal cache access path, which this block does not contain.

Top module: `cache_maint_seq`

## Requirements
- R1: After reset, `busy`, `done`, `wb_req` and `spc_cyc` are all 0, and every line's state reads Invalid. The state codes are 0 Invalid, 1 Shared, 2 Exclusive and 3 Modified.
- R2: The plain flush command (`cmd_clean` = 0) never raises `wb_req` and never signals the writeback special cycle.
- R3: The plain flush command produces exactly one special cycle, and that cycle is Flush (`spc_cyc` = 2'b10).
- R4: The clean-and-flush command (`cmd_clean` = 1) raises one writeback request for each Modified line and none for Shared or Exclusive lines. The requests come in ascending set order, and within a set in ascending way order. Each request carries `wb_addr` = {tag, set index} and `wb_data` = the line data.
- R5: `wb_req`, `wb_addr` and `wb_data` stay constant until `wb_ack` is sampled high.
- R6: After its last writeback, the clean-and-flush command signals Writeback (`spc_cyc` = 2'b01) and then Flush (2'b10). Each code is held until `spc_ack` is sampled high, and 2'b11 never appears.
- R7: `busy` rises in the cycle after a command is accepted and stays high until the Flush cycle is acknowledged. `done` pulses for one cycle, with `busy` low, right after that acknowledge. While idle, no bus output is active.
- R8: A command presented while `busy` is high is ignored. It adds no bus traffic and no extra run.
- R9: A fill (`fill_en`) writes the state, tag and data of one line, but only while the block is idle. A fill presented while `busy` is high has no effect.
- R10: Once `done` pulses, every line's state reads Invalid through the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_clean | input | 1 | 1 = clean-and-flush, 0 = plain flush |
| busy | output | 1 | Maintenance run in progress |
| done | output | 1 | One-cycle completion pulse |
| fill_en | input | 1 | Line load strobe |
| fill_set | input | SET_W | Set index to load |
| fill_way | input | WAY_W | Way to load |
| fill_state | input | 2 | State code to load |
| fill_tag | input | TAG_W | Tag to load |
| fill_data | input | DATA_W | Line data to load |
| look_set | input | SET_W | Set index to read back |
| look_way | input | WAY_W | Way to read back |
| look_state | output | 2 | State of the addressed line |
| wb_req | output | 1 | Line writeback request |
| wb_addr | output | TAG_W+SET_W | Tag and set of the line being written back |
| wb_data | output | DATA_W | Data of the line being written back |
| wb_ack | input | 1 | Writeback accepted |
| spc_cyc | output | 2 | Special cycle: 00 none, 01 writeback, 10 flush |
| spc_ack | input | 1 | Special cycle accepted |

## Verification
Suppose the scan index or the stored state goes wrong. The writeback stream then shows it at the point it happens: a request arrives out of order, carries a foreign address, is missing, or is one too many. The bench checks each request against its own model of the array as the request appears. Suppose instead a line is left valid. That shows on the lookup port as soon as `done` pulses. A broken command or special-cycle sequence shows up in the first wrong `spc_cyc` code or `busy` level, and in the worst case one handshake later.

// File: rtl/cache_maint_seq.sv
module cache_maint_seq #(
  parameter int SETS   = 8,
  parameter int WAYS   = 2,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic                    cmd_clean,
  output logic                    busy,
  output logic                    done,
  input  logic                    fill_en,
  input  logic [SET_W-1:0]        fill_set,
  input  logic [WAY_W-1:0]        fill_way,
  input  logic [1:0]              fill_state,
  input  logic [TAG_W-1:0]        fill_tag,
  input  logic [DATA_W-1:0]       fill_data,
  input  logic [SET_W-1:0]        look_set,
  input  logic [WAY_W-1:0]        look_way,
  output logic [1:0]              look_state,
  output logic                    wb_req,
  output logic [TAG_W+SET_W-1:0]  wb_addr,
  output logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_ack,
  output logic [1:0]              spc_cyc,
  input  logic                    spc_ack
);
  localparam int LINES = SETS * WAYS;
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [1:0] ST_INV = 2'd0;
  localparam logic [1:0] ST_MOD = 2'd3;

  typedef enum logic [2:0] {F_IDLE, F_SCAN, F_WB, F_SPW, F_SPF} fsm_t;

  fsm_t             fsm;
  logic [IDX_W-1:0] idx;
  logic             mode_q;
  logic [1:0]       st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  logic [IDX_W-1:0] fill_idx, look_idx;
  logic [SET_W-1:0] cur_set;
  logic             last, fill_we, line_dirty;

  assign fill_idx   = IDX_W'(fill_set) * IDX_W'(WAYS) + IDX_W'(fill_way);
  assign look_idx   = IDX_W'(look_set) * IDX_W'(WAYS) + IDX_W'(look_way);
  assign cur_set    = SET_W'(idx / IDX_W'(WAYS));
  assign last       = (idx == IDX_W'(LINES - 1));
  assign fill_we    = fill_en && (fsm == F_IDLE);
  assign line_dirty = (st_q[idx] == ST_MOD);

  assign busy       = (fsm != F_IDLE);
  assign wb_req     = (fsm == F_WB);
  assign wb_addr    = {tag_q[idx], cur_set};
  assign wb_data    = dat_q[idx];
  assign spc_cyc    = (fsm == F_SPW) ? 2'b01 : (fsm == F_SPF) ? 2'b10 : 2'b00;
  assign look_state = st_q[look_idx];

  always_ff @(posedge clk) begin
    if (fill_we) begin
      tag_q[fill_idx] <= fill_tag;
      dat_q[fill_idx] <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fsm    <= F_IDLE;
      idx    <= '0;
      mode_q <= 1'b0;
      done   <= 1'b0;
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_INV;
    end else begin
      done <= 1'b0;
      case (fsm)
        F_IDLE: begin
          if (fill_we) st_q[fill_idx] <= fill_state;
          if (cmd_valid) begin
            mode_q <= cmd_clean;
            idx    <= '0;
            fsm    <= F_SCAN;
          end
        end
        F_SCAN, F_WB: begin
          if (fsm == F_SCAN && mode_q && line_dirty) begin
            fsm <= F_WB;
          end else if (fsm == F_SCAN || wb_ack) begin
            st_q[idx] <= ST_INV;
            if (last) fsm <= mode_q ? F_SPW : F_SPF;
            else begin
              idx <= idx + 1'b1;
              fsm <= F_SCAN;
            end
          end
        end
        F_SPW: if (spc_ack) fsm <= F_SPF;
        F_SPF: if (spc_ack) begin
          fsm  <= F_IDLE;
          done <= 1'b1;
        end
        default: fsm <= F_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cache_maint_seq_chk.sv
module cache_maint_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mode,
  input logic              wb_req,
  input logic              wb_ack,
  input logic [ADDR_W-1:0] wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic [1:0]        spc_cyc,
  input logic              spc_ack
);
  p_wb_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req && !wb_ack |=> wb_req && $stable(wb_addr) && $stable(wb_data));

  p_spc_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spc_cyc != 2'b11);

  p_spc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_cyc != 2'b00) && !spc_ack |=> $stable(spc_cyc));

  p_wb_then_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (spc_cyc == 2'b01) && spc_ack |=> spc_cyc == 2'b10);

  p_plain_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode |-> !wb_req && spc_cyc != 2'b01);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(spc_cyc) == 2'b10 && $past(spc_ack));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wb_req && spc_cyc == 2'b00);
endmodule

bind cache_maint_seq cache_maint_seq_chk #(.ADDR_W(TAG_W + SET_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode(mode_q),
  .wb_req(wb_req), .wb_ack(wb_ack), .wb_addr(wb_addr), .wb_data(wb_data),
  .spc_cyc(spc_cyc), .spc_ack(spc_ack)
);

// File: tb/test_cache_maint_seq.sv
module test_cache_maint_seq;
  localparam int SETS = 8, WAYS = 2, TAG_W = 8, DATA_W = 16;
  localparam int SET_W = 3, WAY_W = 1, ADDR_W = TAG_W + SET_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_clean = 1'b0;
  logic busy, done;
  logic fill_en = 1'b0;
  logic [SET_W-1:0] fill_set = '0, look_set = '0;
  logic [WAY_W-1:0] fill_way = '0, look_way = '0;
  logic [1:0] fill_state = '0, look_state;
  logic [TAG_W-1:0] fill_tag = '0;
  logic [DATA_W-1:0] fill_data = '0, wb_data;
  logic wb_req, wb_ack = 1'b0, spc_ack = 1'b0;
  logic [ADDR_W-1:0] wb_addr;
  logic [1:0] spc_cyc;

  int tests = 0, fails = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]       m_st [SETS][WAYS];
  logic [TAG_W-1:0] m_tag[SETS][WAYS];
  logic [DATA_W-1:0] m_dat[SETS][WAYS];

  always #5 clk = ~clk;

  cache_maint_seq #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .DATA_W(DATA_W)) i_cache_maint_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_clean(cmd_clean),
    .busy(busy), .done(done), .fill_en(fill_en), .fill_set(fill_set),
    .fill_way(fill_way), .fill_state(fill_state), .fill_tag(fill_tag),
    .fill_data(fill_data), .look_set(look_set), .look_way(look_way),
    .look_state(look_state), .wb_req(wb_req), .wb_addr(wb_addr),
    .wb_data(wb_data), .wb_ack(wb_ack), .spc_cyc(spc_cyc), .spc_ack(spc_ack));

  function automatic logic [63:0] ev(int kind, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    return {32'(kind), 5'b0, a, d};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: acknowledges each bus item after a 2-cycle stall and compares it.
  initial begin
    int stall = 0;
    forever begin
      @(negedge clk);
      wb_ack = 1'b0;
      spc_ack = 1'b0;
      if (wb_req || spc_cyc != 2'b00) begin
        if (stall < 2) stall++;
        else begin
          logic [63:0] act;
          act = wb_req ? ev(0, wb_addr, wb_data) : ev(int'(spc_cyc), '0, '0);
          if (exp_q.size() == 0) check("R8 unexpected bus item", act, 64'hx);
          else check(tag_q.pop_front(), act, exp_q.pop_front());
          if (wb_req) wb_ack = 1'b1; else spc_ack = 1'b1;
          stall = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic fill(int s, int w, logic [1:0] st, logic [TAG_W-1:0] t, logic [DATA_W-1:0] d, bit model);
    @(negedge clk);
    fill_en = 1'b1; fill_set = SET_W'(s); fill_way = WAY_W'(w);
    fill_state = st; fill_tag = t; fill_data = d;
    @(negedge clk);
    fill_en = 1'b0;
    if (model) begin m_st[s][w] = st; m_tag[s][w] = t; m_dat[s][w] = d; end
  endtask

  task automatic push_expected(bit clean);
    if (clean) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (m_st[s][w] == 2'd3) begin
            exp_q.push_back(ev(0, {m_tag[s][w], SET_W'(s)}, m_dat[s][w]));
            tag_q.push_back("R4 writeback");
          end
      exp_q.push_back(ev(1, '0, '0)); tag_q.push_back("R6 writeback special cycle");
    end
    exp_q.push_back(ev(2, '0, '0)); tag_q.push_back(clean ? "R6 flush special cycle" : "R3 flush special cycle");
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) m_st[s][w] = 2'd0;
  endtask

  task automatic start(bit clean);
    push_expected(clean);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_clean = clean;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R7 busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic wait_done();
    int low = 0;
    while (!done) begin
      @(negedge clk);
      if (!busy && !done) low++;
    end
    check("R7 busy held until final ack", 64'(low), 64'd0);
    check("R7 busy low with done", 64'(busy), 64'd0);
    @(negedge clk);
    check("R7 done is one cycle", 64'(done), 64'd0);
  endtask

  task automatic check_all_invalid(string req);
    int bad = 0;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        look_set = SET_W'(s); look_way = WAY_W'(w);
        #1;
        if (look_state != 2'd0) bad++;
      end
    check(req, 64'(bad), 64'd0);
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin m_st[s][w] = 0; m_tag[s][w] = 0; m_dat[s][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 wb_req", 64'(wb_req), 64'd0);
    check("R1 spc_cyc", 64'(spc_cyc), 64'd0);
    check_all_invalid("R1 states invalid");

    // R9: fill is visible on the lookup port
    fill(0, 1, 2'd3, 8'hA1, 16'h1111, 1);
    look_set = 0; look_way = 1; #1;
    check("R9 fill state", 64'(look_state), 64'd3);
    fill(2, 0, 2'd2, 8'hB2, 16'h2222, 1);
    fill(3, 0, 2'd3, 8'hC3, 16'h3333, 1);
    fill(3, 1, 2'd3, 8'hD4, 16'h4444, 1);
    fill(5, 1, 2'd1, 8'hE5, 16'h5555, 1);
    fill(7, 1, 2'd3, 8'hF6, 16'h6666, 1);

    // R4/R5/R6/R8: clean-and-flush; second command while busy is ignored
    start(1);
    repeat (4) @(negedge clk);
    cmd_valid = 1'b1; cmd_clean = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    check("R4 all items consumed", 64'(exp_q.size()), 64'd0);
    check_all_invalid("R10 invalid after clean");
    repeat (30) @(negedge clk);
    check("R8 no extra run", 64'(busy), 64'd0);

    // R2/R3/R9: plain flush discards dirty lines; fill during busy is ignored
    fill(1, 0, 2'd3, 8'h11, 16'hAAAA, 1);
    fill(6, 1, 2'd3, 8'h22, 16'hBBBB, 1);
    fill(4, 0, 2'd2, 8'h33, 16'hCCCC, 1);
    start(0);
    fill(7, 0, 2'd3, 8'h44, 16'hDDDD, 0);
    wait_done();
    check("R3 one flush only", 64'(exp_q.size()), 64'd0);
    check_all_invalid("R9 R10 invalid after plain flush");
    look_set = 7; look_way = 0; #1;
    check("R9 fill while busy ignored", 64'(look_state), 64'd0);

    // R6: clean-and-flush with no dirty lines, only clean ones
    fill(0, 0, 2'd1, 8'h55, 16'h1234, 1);
    fill(7, 1, 2'd2, 8'h66, 16'h5678, 1);
    start(1);
    wait_done();
    check("R6 special cycles only", 64'(exp_q.size()), 64'd0);

    // R4: every line dirty, full order
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++)
        fill(s, w, 2'd3, TAG_W'(s * 16 + w), DATA_W'(16'h8000 + s * 2 + w), 1);
    start(1);
    wait_done();
    check("R4 full order consumed", 64'(exp_q.size()), 64'd0);
    check_all_invalid("R10 invalid after full clean");

    repeat (10) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule